// File: doc/BRIEF.md
# H-Bridge Control Logic with Fault Latch

This block is the digital controller for one H-bridge power stage with two legs. Two polarity pins pick, per leg, whether the leg is pulled to the supply or to ground. An active-high disable pin and an active-high enable pin gate the bridge. The block drives a high-side and a low-side gate enable for each leg, a sleep indication and an active-low status flag. Each pin also has an "open" indicator that stands for a pin left unconnected. While that indicator is set, the pin reads as its default level.

Protection inputs come from comparators outside the block. They report undervoltage, a hot-die condition at or above the shutdown limit, a warm condition that stays set until the die has cooled past the hysteresis band, and short-circuit. Undervoltage only masks the bridge while it is present. A short-circuit or overtemperature event latches the bridge off. The latch is released by a falling edge of disable or a rising edge of enable, or by power-on reset. The two edges have different temperature conditions for releasing an overtemperature latch. Disable and enable go through a two-flop synchronizer before edge detection. Every output is registered, and a leg passes through one all-off cycle when it reverses.

Top module: `hbridge_ctrl`

## Requirements
- R1: With enable high, disable low and no fault, leg i (bit 0 = leg A, bit 1 = leg B) has hs_on[i] = pol[i] and ls_on[i] = !pol[i]. This covers forward (pol=01), reverse (10), low-side freewheel (00) and high-side freewheel (11).
- R2: hs_on[i] and ls_on[i] are never high together. When a leg reverses, both of its enables are low for one cycle before the opposite switch turns on.
- R3: Disable high turns all four gate enables off, drives flag_n low and keeps sleep low. Driving resumes when disable returns low.
- R4: Enable low turns all gate enables off and sets sleep high. flag_n stays high, even while a fault is present.
- R5: Undervoltage turns all gate enables off and drives flag_n low while present. When it goes away, driving and flag_n high return with no pin edge.
- R6: A short-circuit pulse latches all gate enables off and flag_n low, whatever the polarity pins do afterwards.
- R7: A latched fault is released only by a falling edge of disable or a rising edge of enable. Holding either pin at a steady level releases nothing.
- R8: An overtemperature latch is released by an enable rising edge only while ot_hot is low. It is released by a disable falling edge only while ot_warm is low.
- R9: An open pin reads as its default: polarity high, disable high, enable low.
- R10: While reset is held, all gate enables are low, sleep is high and flag_n is high. Reset also clears every latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pol | input | 2 | Polarity pin per leg, 1 = leg to supply |
| dis | input | 1 | Disable pin, active high |
| en | input | 1 | Enable pin, active high; low = sleep |
| pin_open | input | 4 | Open indicators: [1:0] pol, [2] dis, [3] en |
| uv_fault | input | 1 | Undervoltage present |
| ot_hot | input | 1 | Die at or above the shutdown limit |
| ot_warm | input | 1 | Die not yet below limit minus hysteresis |
| sc_det | input | 1 | Short-circuit detected |
| hs_on | output | 2 | High-side gate enable per leg |
| ls_on | output | 2 | Low-side gate enable per leg |
| sleep | output | 1 | Sleep indication |
| flag_n | output | 1 | Status flag, active low |

## Verification
The bench reverses both legs and samples the single dead cycle. A design without the interlock would show a leg with no gap, or a shoot-through. It holds disable low for a long stretch after a short-circuit to show that a level-sensitive clear would release the latch too early. It also toggles each pin while the die is still warm or hot to catch a design that treats the two release paths the same. Further checks cover undervoltage recovery with no edge, the flag staying high in sleep while a fault is pending, and open-pin defaults that would otherwise leave the bridge driving.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pol,
  input  logic       dis,
  input  logic       en,
  input  logic [3:0] pin_open,
  input  logic       uv_fault,
  input  logic       ot_hot,
  input  logic       ot_warm,
  input  logic       sc_det,
  output logic [1:0] hs_on,
  output logic [1:0] ls_on,
  output logic       sleep,
  output logic       flag_n
);

  logic [1:0] pol_eff;
  logic       dis_eff, en_eff;

  assign pol_eff = pol | pin_open[1:0];
  assign dis_eff = dis | pin_open[2];
  assign en_eff  = en & ~pin_open[3];

  // [0] first sync stage, [1] synchronized value, [2] previous synchronized value
  logic [2:0] dis_sh, en_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_sh <= 3'b111;
      en_sh  <= 3'b000;
    end else begin
      dis_sh <= {dis_sh[1:0], dis_eff};
      en_sh  <= {en_sh[1:0], en_eff};
    end
  end

  logic dis_s, en_s, dis_fall, en_rise, clr_evt, ot_clr;
  assign dis_s    = dis_sh[1];
  assign en_s     = en_sh[1];
  assign dis_fall = dis_sh[2] & ~dis_sh[1];
  assign en_rise  = ~en_sh[2] & en_sh[1];
  assign clr_evt  = dis_fall | en_rise;
  assign ot_clr   = (en_rise & ~ot_hot) | (dis_fall & ~ot_warm);

  logic sc_lat, ot_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      sc_lat <= sc_det | (sc_lat & ~clr_evt);
      ot_lat <= ot_hot | (ot_lat & ~ot_clr);
    end
  end

  logic       drive, fault_any;
  logic [1:0] want_hi, want_lo;
  assign fault_any = dis_s | uv_fault | sc_lat | ot_lat;
  assign drive     = en_s & ~fault_any;
  assign want_hi   = drive ? pol_eff  : 2'b00;
  assign want_lo   = drive ? ~pol_eff : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on  <= 2'b00;
      ls_on  <= 2'b00;
      sleep  <= 1'b1;
      flag_n <= 1'b1;
    end else begin
      hs_on  <= want_hi & ~ls_on;
      ls_on  <= want_lo & ~hs_on;
      sleep  <= ~en_s;
      flag_n <= ~en_s | ~fault_any;
    end
  end

  p_no_shoot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on & ls_on) == 2'b00);

  p_gap_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on[0] |=> !hs_on[0]);

  p_gap_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on[1] |=> !hs_on[1]);

  p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (flag_n && hs_on == 2'b00 && ls_on == 2'b00));

  p_uv_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> (flag_n == sleep));

  p_sc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sc_lat |=> (hs_on == 2'b00 && ls_on == 2'b00));

  p_sc_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sc_lat) |-> $past(clr_evt));

  p_ot_cool_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_lat) |-> !$past(ot_hot));

endmodule

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pol = 2'b01;
  logic       dis = 1'b0, en = 1'b1;
  logic [3:0] pin_open = 4'b0000;
  logic       uv_fault = 1'b0, ot_hot = 1'b0, ot_warm = 1'b0, sc_det = 1'b0;
  logic [1:0] hs_on, ls_on;
  logic       sleep, flag_n;

  hbridge_ctrl i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .pol(pol), .dis(dis), .en(en), .pin_open(pin_open),
    .uv_fault(uv_fault), .ot_hot(ot_hot), .ot_warm(ot_warm), .sc_det(sc_det),
    .hs_on(hs_on), .ls_on(ls_on), .sleep(sleep), .flag_n(flag_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [1:0] hs;
    logic [1:0] ls;
    logic       sl;
    logic       fl;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic want(input logic [1:0] h, input logic [1:0] l, input logic s,
                      input logic f, input string r);
    exp_t e;
    e.hs = h; e.ls = l; e.sl = s; e.fl = f; e.req = r;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (hs_on !== e.hs || ls_on !== e.ls || sleep !== e.sl || flag_n !== e.fl) begin
          bad++;
          $display("FAIL %s: got hs=%b ls=%b sleep=%b flag_n=%b, expected hs=%b ls=%b sleep=%b flag_n=%b",
                   e.req, hs_on, ls_on, sleep, flag_n, e.hs, e.ls, e.sl, e.fl);
        end
      end
    end
  end

  task automatic pulse_dis();
    dis = 1'b1; step(4); dis = 1'b0; step(6);
  endtask

  task automatic pulse_en();
    en = 1'b0; step(4); en = 1'b1; step(6);
  endtask

  initial begin
    step(2);
    want(2'b00, 2'b00, 1'b1, 1'b1, "R10 reset state");
    rst_n = 1'b1; step(6);
    want(2'b01, 2'b10, 1'b0, 1'b1, "R1 forward");

    pol = 2'b10; step(1);
    want(2'b00, 2'b00, 1'b0, 1'b1, "R2 dead cycle on reversal");
    step(1);
    want(2'b10, 2'b01, 1'b0, 1'b1, "R1 reverse");
    pol = 2'b00; step(4);
    want(2'b00, 2'b11, 1'b0, 1'b1, "R1 low-side freewheel");
    pol = 2'b11; step(4);
    want(2'b11, 2'b00, 1'b0, 1'b1, "R1 high-side freewheel");

    dis = 1'b1; step(4);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R3 disabled");
    dis = 1'b0; step(4);
    want(2'b11, 2'b00, 1'b0, 1'b1, "R3 resume");

    en = 1'b0; step(4);
    want(2'b00, 2'b00, 1'b1, 1'b1, "R4 sleep");
    uv_fault = 1'b1; step(2);
    want(2'b00, 2'b00, 1'b1, 1'b1, "R4 flag high in sleep with fault");
    uv_fault = 1'b0; en = 1'b1; step(5);
    want(2'b11, 2'b00, 1'b0, 1'b1, "R4 wake");

    uv_fault = 1'b1; step(2);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R5 undervoltage");
    uv_fault = 1'b0; step(3);
    want(2'b11, 2'b00, 1'b0, 1'b1, "R5 self recovery");

    pol = 2'b01; step(3);
    sc_det = 1'b1; step(1); sc_det = 1'b0; step(3);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R6 short latched");
    pol = 2'b10; step(4);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R6 polarity ignored");
    step(12);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R7 steady level does not clear");
    pulse_dis();
    want(2'b10, 2'b01, 1'b0, 1'b1, "R7 disable edge clears");
    sc_det = 1'b1; step(1); sc_det = 1'b0; step(3);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R7 short latched again");
    pulse_en();
    want(2'b10, 2'b01, 1'b0, 1'b1, "R7 enable edge clears");

    ot_hot = 1'b1; ot_warm = 1'b1; step(2); ot_hot = 1'b0; step(3);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R8 overtemp latched");
    pulse_dis();
    want(2'b00, 2'b00, 1'b0, 1'b0, "R8 disable edge while warm keeps latch");
    pulse_en();
    want(2'b10, 2'b01, 1'b0, 1'b1, "R8 enable edge below limit clears");
    ot_hot = 1'b1; step(3);
    pulse_en();
    want(2'b00, 2'b00, 1'b0, 1'b0, "R8 enable edge while hot keeps latch");
    ot_hot = 1'b0; ot_warm = 1'b0; step(4);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R8 cooling alone does not clear");
    pulse_dis();
    want(2'b10, 2'b01, 1'b0, 1'b1, "R8 disable edge when cool clears");

    pin_open = 4'b1111; step(5);
    want(2'b00, 2'b00, 1'b1, 1'b1, "R9 all open sleeps");
    pin_open = 4'b0100; step(6);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R9 open disable reads high");
    pin_open = 4'b0001; step(6);
    want(2'b11, 2'b00, 1'b0, 1'b1, "R9 open polarity reads high");

    pin_open = 4'b0000; step(3);
    sc_det = 1'b1; step(1); sc_det = 1'b0; step(3);
    want(2'b00, 2'b00, 1'b0, 1'b0, "R10 short before reset");
    rst_n = 1'b0; step(2);
    want(2'b00, 2'b00, 1'b1, 1'b1, "R10 held in reset");
    rst_n = 1'b1; step(6);
    want(2'b10, 2'b01, 1'b0, 1'b1, "R10 reset cleared fault");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule